// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of peripheral devices, each on its own ranked request line, plus one non-maskable input. It offers a single registered request to the processor. When the processor accepts, the block acknowledges only the winning device and waits for that device to return its handler vector. It then forwards the vector to the processor, which uses it as an index into its table of handler entry points.

A small stack of in-service levels supports nesting. While a service is open, requests at or below its level are held off. A strictly higher request may preempt the open service. An end-of-service pulse from the processor closes the innermost service and restores the previous masking level. The non-maskable input ranks above every line and is never masked. Its vector is a fixed parameter and is not read from a device.

Top module: `vic_core`

## Requirements
- R1: After a synchronous reset, `cpu_irq`, every bit of `dev_ack` and `cpu_vec_vld` are low, and no service is open, so every line is eligible.
- R2: A request on an eligible line raises `cpu_irq` on the first rising clock edge after it appears at `dev_req`.
- R3: Line index i has priority level i+1, so a higher index wins. When the processor accepts, `dev_ack` carries exactly one bit, the bit of the highest eligible pending line.
- R4: `dev_ack` rises only on the edge after a cycle with `cpu_ack` and `cpu_irq` both high. It stays unchanged until the acknowledged device raises its bit of `dev_vec_vld`, and it clears on that edge.
- R5: On the edge that sees the acknowledged device's `dev_vec_vld` bit, `cpu_vec` takes that device's vector (bits i*VEC_W upward of `dev_vec`). `cpu_vec_vld` is high for exactly the following cycle.
- R6: While a service is open, a request whose level is at or below the innermost open level keeps `cpu_irq` low.
- R7: A request strictly above the innermost open level raises `cpu_irq` during that service, and its delivery opens a nested service.
- R8: A one-cycle `cpu_eoi` closes the innermost service. The previous level applies from the next edge, so `cpu_irq` for a request masked until then rises one edge after the pop.
- R9: A rising edge on `nmi_in` is recorded on the next clock edge and raises `cpu_irq` on the edge after that, whatever level is open, including an earlier non-maskable service. Its acceptance leaves `dev_ack` low and pulses `cpu_vec_vld` with `cpu_vec` equal to NMI_VEC on the same edge. It opens a service at level N_LINES+1.
- R10: From the edge that accepts a request until its vector is delivered, `cpu_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | N_LINES | Device request lines, index 0 lowest |
| dev_ack | output | N_LINES | One-hot acknowledge to the winning device |
| dev_vec_vld | input | N_LINES | Per-device strobe marking its vector as valid |
| dev_vec | input | N_LINES*VEC_W | Device vectors, device i at bits i*VEC_W upward |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| cpu_irq | output | 1 | Registered interrupt request to the processor |
| cpu_ack | input | 1 | Processor accepts the offered request |
| cpu_vec | output | VEC_W | Handler vector for the processor |
| cpu_vec_vld | output | 1 | One-cycle strobe marking `cpu_vec` as valid |
| cpu_eoi | input | 1 | End-of-service pulse, closes the innermost service |

## Verification
The assertions rely on the following behaviour of the devices and the processor. A device raises its vector strobe only while its acknowledge is high, and it keeps its request up until it is acknowledged. The processor drives `cpu_ack` only while `cpu_irq` is high, and it sends `cpu_eoi` only when a service is open, never in the delivery cycle. The stimulus follows these rules: each handshake runs as a fixed accept-wait-deliver sequence, end-of-service pulses are issued one at a time against a nesting depth that the bench tracks, and nesting never goes beyond the stack depth.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Handshake phase of the controller
  typedef enum logic {
    ST_IDLE = 1'b0,  // offering requests to the processor
    ST_WAIT = 1'b1   // acknowledge out, waiting for the device vector
  } vic_state_e;

endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N_LINES = 8,
  parameter int LVL_W   = 4,
  parameter int ID_W    = 4
) (
  input  logic [N_LINES-1:0] req,
  input  logic               nmi,
  input  logic [LVL_W-1:0]   cur_lvl,
  output logic               any,
  output logic [ID_W-1:0]    win_id
);

  logic [N_LINES-1:0] elig;

  // A line is eligible only when its level is strictly above the open level
  for (genvar g = 0; g < N_LINES; g++) begin : g_elig
    assign elig[g] = req[g] && (LVL_W'(g + 1) > cur_lvl);
  end

  // Later loop iterations override earlier ones, so the highest index wins
  always_comb begin
    any    = 1'b0;
    win_id = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (elig[i]) begin
        any    = 1'b1;
        win_id = ID_W'(i);
      end
    end
    if (nmi) begin
      any    = 1'b1;
      win_id = ID_W'(N_LINES);
    end
  end

endmodule

// File: rtl/vic_lvl_stack.sv
module vic_lvl_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] top_lvl
);

  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] cnt_q;
  logic             full, empty;
  logic [IDX_W-1:0] wr_idx, top_idx;

  assign full    = (cnt_q == PTR_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_idx = IDX_W'(cnt_q - PTR_W'(1));

  // Push and pop together replace the top entry. A push into a full stack
  // overwrites the top entry.
  always_comb begin
    if (pop) begin
      wr_idx = empty ? '0 : top_idx;
    end else begin
      wr_idx = full ? IDX_W'(DEPTH - 1) : IDX_W'(cnt_q);
    end
  end

  // Storage carries no reset, so the memory can be inferred as a RAM
  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_idx] <= push_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push && !pop && !full) begin
      cnt_q <= cnt_q + PTR_W'(1);
    end else if (pop && !push && !empty) begin
      cnt_q <= cnt_q - PTR_W'(1);
    end else if (push && pop && empty) begin
      cnt_q <= PTR_W'(1);
    end
  end

  assign top_lvl = empty ? '0 : mem[top_idx];

endmodule

// File: rtl/vic_fsm.sv
module vic_fsm
  import vic_pkg::*;
#(
  parameter int              N_LINES = 8,
  parameter int              VEC_W   = 8,
  parameter int              ID_W    = 4,
  parameter int              LVL_W   = 4,
  parameter logic [VEC_W-1:0] NMI_VEC = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       offer,
  input  logic                       cpu_ack,
  input  logic [ID_W-1:0]            win_id,
  input  logic [N_LINES-1:0]         dev_vec_vld,
  input  logic [N_LINES*VEC_W-1:0]   dev_vec,
  output logic                       idle,
  output logic                       take,
  output logic [N_LINES-1:0]         dev_ack,
  output logic [VEC_W-1:0]           cpu_vec,
  output logic                       cpu_vec_vld,
  output logic                       push,
  output logic [LVL_W-1:0]           push_lvl
);

  vic_state_e         state_q;
  logic [ID_W-1:0]    sel_q;
  logic [N_LINES-1:0] ack_q;
  logic [VEC_W-1:0]   vec_q;
  logic               vld_q;
  logic               win_nmi, got;
  logic [VEC_W-1:0]   vec_pick;

  assign idle    = (state_q == ST_IDLE);
  assign take    = idle && offer && cpu_ack;
  assign win_nmi = (win_id == ID_W'(N_LINES));
  assign got     = (state_q == ST_WAIT) && |(ack_q & dev_vec_vld);

  // Vector of the acknowledged device, selected by the one-hot acknowledge
  always_comb begin
    vec_pick = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (ack_q[i]) vec_pick = dev_vec[i*VEC_W +: VEC_W];
    end
  end

  assign push     = (take && win_nmi) || got;
  assign push_lvl = got ? (LVL_W'(sel_q) + LVL_W'(1)) : LVL_W'(N_LINES + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      ack_q   <= '0;
      vec_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (win_nmi) begin
              vec_q <= NMI_VEC;
              vld_q <= 1'b1;
            end else begin
              ack_q   <= {{(N_LINES-1){1'b0}}, 1'b1} << win_id;
              sel_q   <= win_id;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (got) begin
            vec_q   <= vec_pick;
            vld_q   <= 1'b1;
            ack_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_ack     = ack_q;
  assign cpu_vec     = vec_q;
  assign cpu_vec_vld = vld_q;

endmodule

// File: rtl/vic_core.sv
module vic_core #(
  parameter int               N_LINES    = 8,
  parameter int               VEC_W      = 8,
  parameter int               NEST_DEPTH = 4,
  parameter logic [VEC_W-1:0] NMI_VEC    = 8'hFE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_LINES-1:0]       dev_req,
  output logic [N_LINES-1:0]       dev_ack,
  input  logic [N_LINES-1:0]       dev_vec_vld,
  input  logic [N_LINES*VEC_W-1:0] dev_vec,
  input  logic                     nmi_in,
  output logic                     cpu_irq,
  input  logic                     cpu_ack,
  output logic [VEC_W-1:0]         cpu_vec,
  output logic                     cpu_vec_vld,
  input  logic                     cpu_eoi
);

  localparam int LVL_W = $clog2(N_LINES + 2);
  localparam int ID_W  = $clog2(N_LINES + 1);

  logic             nmi_q, nmi_pend;
  logic             irq_q;
  logic [ID_W-1:0]  win_q;
  logic             pick_any;
  logic [ID_W-1:0]  pick_id;
  logic [LVL_W-1:0] top_lvl;
  logic             idle, take, push;
  logic [LVL_W-1:0] push_lvl;
  logic             nmi_take;

  assign nmi_take = take && (win_q == ID_W'(N_LINES));

  // Non-maskable input is edge sensitive, latched until accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= (nmi_pend && !nmi_take) || (nmi_in && !nmi_q);
    end
  end

  vic_prio_pick #(
    .N_LINES (N_LINES),
    .LVL_W   (LVL_W),
    .ID_W    (ID_W)
  ) u_pick (
    .req     (dev_req),
    .nmi     (nmi_pend),
    .cur_lvl (top_lvl),
    .any     (pick_any),
    .win_id  (pick_id)
  );

  // Registered offer: request and winner move together, once per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      win_q <= '0;
    end else if (idle && !take) begin
      irq_q <= pick_any;
      win_q <= pick_id;
    end else begin
      irq_q <= 1'b0;
    end
  end

  vic_fsm #(
    .N_LINES     (N_LINES),
    .VEC_W       (VEC_W),
    .ID_W        (ID_W),
    .LVL_W       (LVL_W),
    .NMI_VEC     (NMI_VEC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .offer       (irq_q),
    .cpu_ack     (cpu_ack),
    .win_id      (win_q),
    .dev_vec_vld (dev_vec_vld),
    .dev_vec     (dev_vec),
    .idle        (idle),
    .take        (take),
    .dev_ack     (dev_ack),
    .cpu_vec     (cpu_vec),
    .cpu_vec_vld (cpu_vec_vld),
    .push        (push),
    .push_lvl    (push_lvl)
  );

  vic_lvl_stack #(
    .DEPTH    (NEST_DEPTH),
    .LVL_W    (LVL_W)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (cpu_eoi),
    .push_lvl (push_lvl),
    .top_lvl  (top_lvl)
  );

  assign cpu_irq = irq_q;

endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] dev_ack,
  input logic [N_LINES-1:0] dev_vec_vld,
  input logic               cpu_irq,
  input logic               cpu_ack,
  input logic               cpu_vec_vld
);

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_ack));

  assert_ack_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(|dev_ack) |-> $past(cpu_ack && cpu_irq));

  assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
    ((dev_ack != '0) && !(|(dev_ack & dev_vec_vld))) |=> $stable(dev_ack));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (|(dev_ack & dev_vec_vld)) |=> (dev_ack == '0));

  assert_vec_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (|(dev_ack & dev_vec_vld)) |=> cpu_vec_vld);

  assert_vld_single_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_vec_vld |=> !cpu_vec_vld);

  assert_irq_drops_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && cpu_irq) |=> !cpu_irq);

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_ack != '0) |-> !cpu_irq);

endmodule

bind vic_core vic_core_chk #(
  .N_LINES     (N_LINES)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dev_ack     (dev_ack),
  .dev_vec_vld (dev_vec_vld),
  .cpu_irq     (cpu_irq),
  .cpu_ack     (cpu_ack),
  .cpu_vec_vld (cpu_vec_vld)
);

// File: tb/vic_core_tb.sv
module vic_core_tb;

  localparam int N   = 8;
  localparam int VW  = 8;
  localparam logic [VW-1:0] NMIV = 8'hFE;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    dev_req = '0;
  logic [N-1:0]    dev_ack;
  logic [N-1:0]    dev_vec_vld = '0;
  logic [N*VW-1:0] dev_vec;
  logic            nmi_in = 1'b0;
  logic            cpu_irq;
  logic            cpu_ack = 1'b0;
  logic [VW-1:0]   cpu_vec;
  logic            cpu_vec_vld;
  logic            cpu_eoi = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [VW-1:0] exp_q [$];

  always #5 clk = ~clk;

  // Device i returns vector 0x40 + i
  for (genvar g = 0; g < N; g++) begin : g_vec
    assign dev_vec[g*VW +: VW] = VW'(8'h40 + g);
  end

  vic_core #(
    .N_LINES     (N),
    .VEC_W       (VW),
    .NEST_DEPTH  (4),
    .NMI_VEC     (NMIV)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .dev_req     (dev_req),
    .dev_ack     (dev_ack),
    .dev_vec_vld (dev_vec_vld),
    .dev_vec     (dev_vec),
    .nmi_in      (nmi_in),
    .cpu_irq     (cpu_irq),
    .cpu_ack     (cpu_ack),
    .cpu_vec     (cpu_vec),
    .cpu_vec_vld (cpu_vec_vld),
    .cpu_eoi     (cpu_eoi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every delivered vector is compared with the scoreboard (R5, R9)
  always @(negedge clk) begin
    if (!rst && cpu_vec_vld) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected vector", int'(cpu_vec), 0);
      end else begin
        logic [VW-1:0] e;
        e = exp_q.pop_front();
        chk(cpu_vec == e, "R5 vector to cpu", int'(cpu_vec), int'(e));
      end
    end
  end

  // Driver: accept the offer, wait, let device k deliver its vector
  task automatic serve(input int k);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    chk(dev_ack == N'(1 << k), "R3 one-hot ack to winner", int'(dev_ack), 1 << k);
    chk(cpu_irq == 1'b0, "R10 irq low during handshake", int'(cpu_irq), 0);
    tick();
    chk(dev_ack == N'(1 << k), "R4 ack held until vector", int'(dev_ack), 1 << k);
    exp_q.push_back(VW'(8'h40 + k));
    dev_vec_vld[k] = 1'b1;
    dev_req[k]     = 1'b0;
    tick();
    dev_vec_vld[k] = 1'b0;
    chk(dev_ack == '0, "R4 ack cleared after vector", int'(dev_ack), 0);
  endtask

  task automatic serve_nmi();
    exp_q.push_back(NMIV);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    chk(dev_ack == '0, "R9 no device ack for nmi", int'(dev_ack), 0);
    chk(cpu_vec_vld == 1'b1, "R9 nmi vector same edge", int'(cpu_vec_vld), 1);
  endtask

  task automatic eoi();
    cpu_eoi = 1'b1;
    tick();
    cpu_eoi = 1'b0;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(cpu_irq == 1'b0, "R1 irq after reset", int'(cpu_irq), 0);
    chk(dev_ack == '0, "R1 ack after reset", int'(dev_ack), 0);
    chk(cpu_vec_vld == 1'b0, "R1 vld after reset", int'(cpu_vec_vld), 0);

    // R2 single request, one-edge latency
    dev_req[2] = 1'b1;
    tick();
    chk(cpu_irq == 1'b1, "R2 irq one edge after request", int'(cpu_irq), 1);
    serve(2);
    tick();
    eoi();
    tick();

    // R3 three lines at once, highest index wins
    dev_req[1] = 1'b1; dev_req[3] = 1'b1; dev_req[5] = 1'b1;
    tick();
    chk(cpu_irq == 1'b1, "R3 irq with several requests", int'(cpu_irq), 1);
    serve(5);
    tick(2);
    // R6 lower lines masked by level 6
    chk(cpu_irq == 1'b0, "R6 lower lines held off", int'(cpu_irq), 0);
    dev_req[5] = 1'b1;
    tick(2);
    chk(cpu_irq == 1'b0, "R6 same level held off", int'(cpu_irq), 0);
    dev_req[5] = 1'b0;

    // R7 higher line preempts
    dev_req[7] = 1'b1;
    tick();
    chk(cpu_irq == 1'b1, "R7 higher line preempts", int'(cpu_irq), 1);
    serve(7);
    tick();
    chk(cpu_irq == 1'b0, "R6 nested level masks", int'(cpu_irq), 0);

    // R8 two pops restore level 0, line 3 then wins
    eoi();
    tick();
    chk(cpu_irq == 1'b0, "R8 level 6 still masks", int'(cpu_irq), 0);
    eoi();
    chk(cpu_irq == 1'b0, "R8 irq one edge after pop", int'(cpu_irq), 0);
    tick();
    chk(cpu_irq == 1'b1, "R8 masked request released", int'(cpu_irq), 1);
    serve(3);
    tick();

    // R9 nmi above open level 4
    nmi_in = 1'b1;
    tick();
    chk(cpu_irq == 1'b0, "R9 nmi recorded first", int'(cpu_irq), 0);
    tick();
    chk(cpu_irq == 1'b1, "R9 nmi unmasked", int'(cpu_irq), 1);
    serve_nmi();
    nmi_in = 1'b0;
    dev_req[7] = 1'b1;
    tick(2);
    chk(cpu_irq == 1'b0, "R6 line 7 masked under nmi", int'(cpu_irq), 0);
    nmi_in = 1'b1;
    tick(2);
    chk(cpu_irq == 1'b1, "R9 nmi over nmi", int'(cpu_irq), 1);
    serve_nmi();
    nmi_in = 1'b0;

    // Unwind the three open services; line 7 then line 1
    eoi(); eoi(); eoi();
    tick();
    chk(cpu_irq == 1'b1, "R8 line 7 after unwind", int'(cpu_irq), 1);
    serve(7);
    eoi();
    tick();
    chk(cpu_irq == 1'b1, "R2 line 1 offered", int'(cpu_irq), 1);
    serve(1);
    eoi();
    tick(2);
    chk(cpu_irq == 1'b0, "R1 quiet when nothing pending", int'(cpu_irq), 0);
    chk(exp_q.size() == 0, "R5 all vectors delivered", exp_q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule